// File: doc/BRIEF.md
# Serial-Input Single-Pulse Position Modulator

The block turns a serial bit stream into a single-pulse position modulated (PPM) waveform. Bits arrive on a one-bit input qualified by a valid strobe and are packed into symbols of `SYM_BITS` bits each. A frame has `2**SYM_BITS` slots, one per clock, so the default of four bits per symbol gives 16 slots. The first bit of a group is the least significant bit of the symbol. A free-running slot counter sets the frame grid. At each frame boundary the most recently completed symbol is captured into a hold register and kept for the whole of the next frame. The output pulses high in the one slot whose index equals the held value.

The upstream source is expected to present one bit every `2**SYM_BITS / SYM_BITS` clocks, which is four clocks per bit by default. At that rate, one symbol is assembled per frame. A frame-start marker is high during slot 0 of every frame. The marker lets downstream logic or a bench align to the slot grid. Output lags input by at least one symbol time, because a symbol can only be sent in the frame after the one in which it was completed.

Top module: `ppm_modulator`

## Requirements
- R1: In the first clock cycle after synchronous reset is released, `frame_start` is high and `ppm_out` is low. That cycle is slot 0 of a frame.
- R2: `frame_start` is high for exactly one cycle in every `2**SYM_BITS` cycles, and successive markers are exactly `2**SYM_BITS` cycles apart.
- R3: A symbol whose bits arrive in the order b0, b1, ..., b(n-1) is given the slot index b0 + 2·b1 + ... + 2^(n-1)·b(n-1). The first accepted bit has weight 1.
- R4: A symbol completed in frame k is sent in frame k+1. In that frame `ppm_out` is high in exactly one cycle, the cycle whose slot index (counted from 0 at `frame_start`) equals the symbol. The held symbol does not change within the frame.
- R5: In a frame for which no symbol was completed during the previous frame, `ppm_out` stays low in every slot. This includes the first frame after reset.
- R6: `bit_in` is ignored in every cycle in which `bit_valid` is low.
- R7: A symbol whose last bit is accepted in the final slot of a frame is sent in the immediately following frame.
- R8: When more than one symbol completes within a single frame, only the last one completed is sent in the next frame.
- R9: Asserting reset part-way through a frame forces `ppm_out` low at once. It also discards the held symbol, any pending symbol and any partly assembled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock; one cycle per slot |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Accepts `bit_in` on this clock edge when high |
| ppm_out | output | 1 | Pulse position modulated output |
| frame_start | output | 1 | High during slot 0 of each frame |

## Verification
All sixteen symbol values are swept frame after frame, with `bit_in` toggling as garbage whenever the strobe is low. A design with reversed bit weighting would therefore place pulses at mirrored slots. A design that sampled bits without qualification would also misplace them.

The last-slot arrival case targets an off-by-one in the boundary load. Such a design would either drop that symbol or delay it by a whole frame. The stall frames catch a hold register that is never emptied: that design would repeat the old pulse. Two symbols packed into one frame expose a design that keeps the first rather than the last. A reset in mid-frame catches state that survives reset and leaks a pulse into the next frame.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    // Widest symbol any instance may use; narrower symbols zero-extend.
    localparam int unsigned SYM_MAX = 8;

    typedef logic [SYM_MAX-1:0] sym_value_t;

    // A symbol plus a flag saying whether it carries data.
    typedef struct packed {
        logic       valid;
        sym_value_t value;
    } sym_word_t;

    // What the hold stage does on a given clock edge.
    typedef enum logic [2:0] {
        HOLD_KEEP,
        HOLD_STASH,
        HOLD_LOAD_FRESH,
        HOLD_LOAD_PENDING,
        HOLD_LOAD_EMPTY
    } hold_action_e;

    // Clocks between input bits that keep input and frame rates equal.
    function automatic int unsigned clocks_per_bit(input int unsigned sym_bits);
        return (32'd1 << sym_bits) / sym_bits;
    endfunction

endpackage

// File: rtl/ppm_slot_counter.sv
module ppm_slot_counter #(
    parameter int unsigned SYM_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    output logic [SYM_BITS-1:0] slot,
    output logic                last_slot,
    output logic                first_slot
);

    logic [SYM_BITS-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot       = slot_q;
    assign last_slot  = &slot_q;
    assign first_slot = (slot_q == '0);

endmodule

// File: rtl/ppm_deserializer.sv
module ppm_deserializer
    import ppm_pkg::*;
#(
    parameter int unsigned SYM_BITS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_in,
    input  logic      bit_valid,
    output sym_word_t fresh
);

    localparam int unsigned CW = $clog2(SYM_BITS);

    logic [SYM_BITS-1:0] shift_q;
    logic [CW-1:0]       count_q;
    logic                group_done;
    logic [SYM_BITS-1:0] assembled;

    // Bits enter at the top and move down, so the first bit ends at bit 0.
    assign assembled  = {bit_in, shift_q[SYM_BITS-1:1]};
    assign group_done = bit_valid && (count_q == CW'(SYM_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            count_q <= '0;
        end else if (bit_valid) begin
            shift_q <= assembled;
            count_q <= group_done ? '0 : count_q + 1'b1;
        end
    end

    always_comb begin
        fresh.valid = group_done;
        fresh.value = SYM_MAX'(assembled);
    end

endmodule

// File: rtl/ppm_symbol_hold.sv
module ppm_symbol_hold
    import ppm_pkg::*;
#(
    parameter int unsigned SYM_BITS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      boundary,
    input  sym_word_t fresh,
    output sym_word_t held
);

    sym_word_t    pending_q;
    sym_word_t    held_q;
    hold_action_e action;

    always_comb begin
        if (boundary) begin
            if (fresh.valid) begin
                action = HOLD_LOAD_FRESH;
            end else if (pending_q.valid) begin
                action = HOLD_LOAD_PENDING;
            end else begin
                action = HOLD_LOAD_EMPTY;
            end
        end else if (fresh.valid) begin
            action = HOLD_STASH;
        end else begin
            action = HOLD_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            held_q    <= '0;
        end else begin
            unique case (action)
                HOLD_STASH: begin
                    pending_q <= fresh;
                end
                HOLD_LOAD_FRESH: begin
                    held_q          <= fresh;
                    pending_q.valid <= 1'b0;
                end
                HOLD_LOAD_PENDING: begin
                    held_q          <= pending_q;
                    pending_q.valid <= 1'b0;
                end
                HOLD_LOAD_EMPTY: begin
                    held_q.valid <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    assign held = held_q;

endmodule

// File: rtl/ppm_modulator.sv
module ppm_modulator
    import ppm_pkg::*;
#(
    parameter int unsigned SYM_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_valid,
    output logic ppm_out,
    output logic frame_start
);

    localparam int unsigned SLOTS = 1 << SYM_BITS;

    logic [SYM_BITS-1:0] slot;
    logic                last_slot;
    logic                first_slot;
    sym_word_t           fresh;
    sym_word_t           held;
    sym_value_t          held_value;
    logic                held_valid;

    ppm_slot_counter #(.SYM_BITS(SYM_BITS)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .last_slot  (last_slot),
        .first_slot (first_slot)
    );

    ppm_deserializer #(.SYM_BITS(SYM_BITS)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .fresh     (fresh)
    );

    ppm_symbol_hold #(.SYM_BITS(SYM_BITS)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .boundary (last_slot),
        .fresh    (fresh),
        .held     (held)
    );

    assign held_value  = held.value;
    assign held_valid  = held.valid;
    assign ppm_out     = held_valid && (SYM_MAX'(slot) == held_value);
    assign frame_start = first_slot;

endmodule

// File: rtl/ppm_modulator_chk.sv
module ppm_modulator_chk
    import ppm_pkg::*;
#(
    parameter int unsigned SYM_BITS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       ppm_out,
    input logic       frame_start,
    input sym_value_t held_value,
    input logic       held_valid
);

    localparam int unsigned SLOTS = 1 << SYM_BITS;

    logic [SYM_BITS:0] gap_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            gap_q  <= frame_start ? '0 : gap_q + 1'b1;
            seen_q <= frame_start ? ppm_out : (seen_q | ppm_out);
        end
    end

    AST_RESET_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (frame_start && !ppm_out)); // R1

    AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !$past(rst)) |-> (gap_q == (SYM_BITS+1)'(SLOTS - 1))); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ppm_out && !frame_start) |-> !seen_q); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> ($stable(held_value) && $stable(held_valid))); // R4

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !held_valid); // R9

endmodule

bind ppm_modulator ppm_modulator_chk #(.SYM_BITS(SYM_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ppm_out     (ppm_out),
    .frame_start (frame_start),
    .held_value  (held_value),
    .held_valid  (held_valid)
);

// File: tb/tb_ppm_modulator.sv
`timescale 1ns/1ps
module tb_ppm_modulator;

    localparam int SYM_BITS = 4;
    localparam int SLOTS    = 1 << SYM_BITS;
    localparam int BIT_GAP  = SLOTS / SYM_BITS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic ppm_out;
    logic frame_start;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ppm_modulator #(.SYM_BITS(SYM_BITS)) dut (
        .clk         (clk),
        .rst         (rst),
        .bit_in      (bit_in),
        .bit_valid   (bit_valid),
        .ppm_out     (ppm_out),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // Called on a negedge at slot 0. Sends nbits of data, one every step
    // slots from slot off onward. Checks the marker and the pulse, then
    // returns on the negedge that starts the next frame.
    task automatic run_frame(input logic [15:0] data, input int nbits,
                             input int step, input int off,
                             input int exp_slot, input string req);
        int pulses = 0;
        int pos = -1;
        int fs_bad = 0;
        for (int s = 0; s < SLOTS; s++) begin
            if (frame_start != (s == 0)) fs_bad++;
            if (ppm_out) begin
                pulses++;
                pos = s;
            end
            if (s >= off && ((s - off) % step) == 0 && ((s - off) / step) < nbits) begin
                bit_valid = 1'b1;
                bit_in    = data[(s - off) / step];
            end else begin
                bit_valid = 1'b0;
                bit_in    = s[0] ^ s[2];   // garbage while not valid (R6)
            end
            @(negedge clk);
        end
        bit_valid = 1'b0;
        chk(fs_bad == 0, "R2 frame_start only in slot 0", fs_bad, 0);
        if (exp_slot < 0) begin
            chk(pulses == 0, {req, " pulse count in empty frame"}, pulses, 0);
        end else begin
            chk(pulses == 1 && pos == exp_slot, {req, " pulse slot"}, pos, exp_slot);
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: this negedge is the first cycle after release
        chk(frame_start == 1'b1, "R1 frame_start after reset", int'(frame_start), 1);
        chk(ppm_out == 1'b0, "R1 ppm_out after reset", int'(ppm_out), 0);

        // R5: first frame has nothing to send
        run_frame(16'd5, 4, BIT_GAP, 0, -1, "R5");
        prev = 5;
        // R3 R4 R6: sweep all symbol values
        for (int v = 0; v < SLOTS; v++) begin
            run_frame(16'(v), 4, BIT_GAP, 0, prev, "R3 R4 R6 sweep");
            prev = v;
        end
        // R7: last bit lands in slot 15
        run_frame(16'd9, 4, BIT_GAP, BIT_GAP - 1, prev, "R4");
        run_frame(16'd0, 0, BIT_GAP, 0, 9, "R7 last-slot symbol");
        // R5: stalled input gives an empty frame
        run_frame(16'd0, 0, BIT_GAP, 0, -1, "R5 stall");
        // R8: two symbols in one frame, later one wins
        run_frame({8'd0, 4'd12, 4'd3}, 8, 2, 0, -1, "R5");
        run_frame(16'd0, 0, BIT_GAP, 0, 12, "R8 latest symbol");
        // R9: reset in mid-frame discards a held symbol
        run_frame(16'd10, 4, BIT_GAP, 0, -1, "R5");
        // Partial bits to be dropped by the reset
        for (int s = 0; s < 6; s++) begin
            bit_valid = (s == 1 || s == 3);
            bit_in    = 1'b1;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(ppm_out == 1'b0, "R9 ppm_out during reset", int'(ppm_out), 0);
        @(negedge clk);
        rst = 1'b0;
        chk(frame_start == 1'b1, "R9 realigned after reset", int'(frame_start), 1);
        run_frame(16'd6, 2, BIT_GAP, 0, -1, "R9 held symbol discarded");
        // Two stale partial bits plus these two would make a symbol if kept
        run_frame(16'd1, 2, BIT_GAP, 0, -1, "R9 partial bits discarded");
        run_frame(16'd0, 0, BIT_GAP, 0, 6, "R9 clean assembly after reset");

        summary();
        $finish;
    end

endmodule